// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate Two-Port SRAM

This block is a synthesizable storage model with one read-only port and one write-only port. The two ports work at the same time. Each accepted request names a group of four consecutive words and moves all four of them. Words travel on both edges of `clk`, so each clock cycle carries two words.

A read is requested with `rd_sel_n` low at a rising edge. The group address is sampled at that same rising edge. A write is requested with `wr_sel_n` low at a rising edge. Its group address is sampled at the following falling edge, which lets one address bus serve both ports in the same cycle. Every write beat carries its own active-low byte enables. A read returns the stored words in the fixed order 0, 1, 2, 3 within the group, and `rd_valid` marks the four half-cycles that carry them. `echo_clk` follows `clk` so that a receiver can capture read data against it. Reset clears the control pipeline and the output stage but leaves the array contents alone.

Top module: `qb4_sram`

## Requirements
- R1: A read and a write accepted at the same rising edge both complete, and neither one delays the other.
- R2: A burst covers the four words of one group. The word index inside the group is given by the two low bits, which step 00, 01, 10, 11, and the read returns the words in that order.
- R3: The write beats of a write accepted at rising edge N are captured at the falling edge of cycle N, the rising edge of N+1, the falling edge of N+1 and the rising edge of N+2, in word order 0 to 3. The write group is sampled from `addr` at the falling edge of cycle N. The read group is sampled at its accepting rising edge.
- R4: Bit b of `wr_bw_n` belongs to byte b of the beat, which is data bits [8b+7:8b]. A low bit writes that byte. A high bit leaves that stored byte unchanged.
- R5: Both selects are active low and are sampled only at rising edges. In a cycle with both selects high nothing is read or written. Data, byte enables and address driven outside a write burst have no effect.
- R6: A port accepts at most one request every two cycles. A select held low in the cycle right after that port accepted a request is ignored.
- R7: For a read accepted at rising edge N, word 0 is driven from the falling edge of cycle N+1, and words 1, 2 and 3 follow on the next three edges. `rd_valid` is high for exactly those four half-cycles.
- R8: A read returns the effect of every write accepted at the same rising edge or an earlier one, including a write whose beats are still arriving. It returns nothing from writes accepted later.
- R9: `rd_data` is zero whenever `rd_valid` is low.
- R10: While reset is asserted `rd_valid` and `rd_data` are zero and no burst is in progress. The array contents written before reset remain readable after it.
- R11: `echo_clk` has the same level as `clk` at all times, so every read-data change lines up with an `echo_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Both edges move data. |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled at the rising edge |
| wr_sel_n | input | 1 | Active-low write request, sampled at the rising edge |
| addr | input | GRP_W | Group address: read group at the rising edge, write group at the falling edge |
| wr_data | input | DATA_W | Write beat data, captured on both edges during a write burst |
| wr_bw_n | input | DATA_W/BYTE_W | Active-low byte enables for each write beat |
| rd_data | output | DATA_W | Read beat data, zero when not valid |
| rd_valid | output | 1 | High during each of the four read half-cycles |
| echo_clk | output | 1 | Free-running clock that follows `clk` |

## Verification
The array is first filled with full-mask writes, so each group and word order can be read back with known contents. Random byte masks then separate a beat's enables from those of its neighbours. Same-cycle write and read pairs to one group exercise the forwarding path. A write followed by a read one cycle later, and a read followed by a write one cycle later, show that the visibility boundary sits exactly at the accepting edge. Back-to-back selects, junk data during idle cycles and a reset in the middle of the run check that ignored inputs change nothing. A long random mix of reads, writes, idle cycles and groups is compared half-cycle by half-cycle against a behavioural reference array.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

  // Each burst is handled as two halves of two words each.
  typedef enum logic {
    PAIR_FIRST  = 1'b0,
    PAIR_SECOND = 1'b1
  } pair_e;
endpackage

// File: rtl/qb4_array.sv
module qb4_array
  import qb4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NBYTE  = 2,
  parameter int GRP_W  = 4
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [GRP_W-1:0]            wgrp,
  input  pair_e                       wpair,
  input  logic [1:0][DATA_W-1:0]      wd,
  input  logic [1:0][NBYTE-1:0]       wm,
  input  logic                        ren,
  input  logic [GRP_W-1:0]            rgrp,
  input  pair_e                       rpair,
  output logic [1:0][DATA_W-1:0]      rq,
  output logic                        fwd_hit
);
  localparam int BYTE_W = DATA_W / NBYTE;
  localparam int IDX_W  = GRP_W + BEAT_W;
  localparam int WORDS  = 1 << IDX_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Replaces each byte whose enable is low. Bytes with a high enable keep
  // their stored value.
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [NBYTE-1:0]  keep_n);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int b = 0; b < NBYTE; b++)
      if (!keep_n[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] word_idx(input logic [GRP_W-1:0] g,
                                                input pair_e p, input logic odd);
    return {g, p, odd};
  endfunction

  // A read fetching the same half of the same group that is being committed
  // at this edge takes the merged value.
  assign fwd_hit = we && ren && (wgrp == rgrp) && (wpair == rpair);

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [DATA_W-1:0] stored;
    assign stored = mem[word_idx(rgrp, rpair, 1'(k))];
    assign rq[k]  = fwd_hit ? lane_merge(stored, wd[k], wm[k]) : stored;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < 2; k++)
        mem[word_idx(wgrp, wpair, 1'(k))] <=
          lane_merge(mem[word_idx(wgrp, wpair, 1'(k))], wd[k], wm[k]);
    end
  end
endmodule

// File: rtl/qb4_wr_path.sv
module qb4_wr_path
  import qb4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NBYTE  = 2,
  parameter int GRP_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_sel_n,
  input  logic [GRP_W-1:0]       addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NBYTE-1:0]       wr_bw_n,
  output logic                   take,
  output logic                   we,
  output logic [GRP_W-1:0]       wgrp,
  output pair_e                  wpair,
  output logic [1:0][DATA_W-1:0] wd,
  output logic [1:0][NBYTE-1:0]  wm
);
  logic              act;
  pair_e             pair;
  logic [GRP_W-1:0]  grp;
  logic [DATA_W-1:0] lo_d;
  logic [NBYTE-1:0]  lo_m;

  assign take = !wr_sel_n && !(act && pair == PAIR_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      pair <= PAIR_FIRST;
    end else if (take) begin
      act  <= 1'b1;
      pair <= PAIR_FIRST;
    end else if (act && pair == PAIR_FIRST) begin
      pair <= PAIR_SECOND;
    end else begin
      act <= 1'b0;
    end
  end

  // The falling edge captures the even beat and, in the first half, the group.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp  <= '0;
      lo_d <= '0;
      lo_m <= '1;
    end else if (act) begin
      lo_d <= wr_data;
      lo_m <= wr_bw_n;
      if (pair == PAIR_FIRST) grp <= addr;
    end
  end

  // The odd beat comes straight from the pins at the committing rising edge.
  assign we    = act;
  assign wgrp  = grp;
  assign wpair = pair;
  assign wd[0] = lo_d;
  assign wd[1] = wr_data;
  assign wm[0] = lo_m;
  assign wm[1] = wr_bw_n;
endmodule

// File: rtl/qb4_rd_path.sv
module qb4_rd_path
  import qb4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GRP_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_sel_n,
  input  logic [GRP_W-1:0]       addr,
  input  logic [1:0][DATA_W-1:0] rq,
  output logic                   take,
  output logic                   ren,
  output logic [GRP_W-1:0]       rgrp,
  output pair_e                  rpair,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  output logic                   v_fall_o
);
  logic                   act;
  pair_e                  pair;
  logic [GRP_W-1:0]       grp;
  logic                   pair_vld;
  logic [1:0][DATA_W-1:0] pd;
  logic [DATA_W-1:0]      q_rise, q_fall;
  logic                   v_rise, v_fall;

  assign take = !rd_sel_n && !(act && pair == PAIR_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      pair     <= PAIR_FIRST;
      grp      <= '0;
      pair_vld <= 1'b0;
      pd       <= '0;
      q_rise   <= '0;
      v_rise   <= 1'b0;
    end else begin
      v_rise   <= pair_vld;
      q_rise   <= pair_vld ? pd[1] : '0;
      pair_vld <= act;
      if (act) pd <= rq;
      if (take) begin
        act  <= 1'b1;
        pair <= PAIR_FIRST;
        grp  <= addr;
      end else if (act && pair == PAIR_FIRST) begin
        pair <= PAIR_SECOND;
      end else begin
        act <= 1'b0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_fall <= '0;
      v_fall <= 1'b0;
    end else begin
      q_fall <= pair_vld ? pd[0] : '0;
      v_fall <= pair_vld;
    end
  end

  assign ren      = act;
  assign rgrp     = grp;
  assign rpair    = pair;
  assign rd_data  = clk ? q_rise : q_fall;
  assign rd_valid = clk ? v_rise : v_fall;
  assign v_fall_o = v_fall;
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
  import qb4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int GRP_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_sel_n,
  input  logic                     wr_sel_n,
  input  logic [GRP_W-1:0]         addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/BYTE_W-1:0] wr_bw_n,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic                     echo_clk
);
  localparam int NBYTE = DATA_W / BYTE_W;

  // Named internal events, watched by the bound checker.
  logic                   rd_take, wr_take, wr_commit, fwd_hit, rd_v_fall, rd_ren;
  logic [GRP_W-1:0]       wgrp, rgrp;
  pair_e                  wpair, rpair;
  logic [1:0][DATA_W-1:0] wd, rq;
  logic [1:0][NBYTE-1:0]  wm;

  qb4_wr_path #(.DATA_W(DATA_W), .NBYTE(NBYTE), .GRP_W(GRP_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_sel_n(wr_sel_n), .addr(addr),
    .wr_data(wr_data), .wr_bw_n(wr_bw_n), .take(wr_take), .we(wr_commit),
    .wgrp(wgrp), .wpair(wpair), .wd(wd), .wm(wm)
  );

  qb4_array #(.DATA_W(DATA_W), .NBYTE(NBYTE), .GRP_W(GRP_W)) u_mem (
    .clk(clk), .we(wr_commit), .wgrp(wgrp), .wpair(wpair), .wd(wd), .wm(wm),
    .ren(rd_ren), .rgrp(rgrp), .rpair(rpair), .rq(rq), .fwd_hit(fwd_hit)
  );

  qb4_rd_path #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .addr(addr), .rq(rq),
    .take(rd_take), .ren(rd_ren), .rgrp(rgrp), .rpair(rpair),
    .rd_data(rd_data), .rd_valid(rd_valid), .v_fall_o(rd_v_fall)
  );

  assign echo_clk = clk;
endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_take,
  input logic              wr_take,
  input logic              wr_commit,
  input logic              fwd_hit,
  input logic              rd_v_fall,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);
  assert_rd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> !rd_take);

  assert_wr_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !wr_take);

  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |-> ##2 rd_v_fall);

  assert_valid_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_v_fall |-> ($past(rd_take, 2) || $past(rd_take, 3)));

  assert_commit_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> ($past(wr_take, 1) || $past(wr_take, 2)));

  assert_fwd_same_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> ($past(rd_take && wr_take, 1) || $past(rd_take && wr_take, 2)));

  assert_idle_zero_R9: assert property (@(negedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
endmodule

bind qb4_sram qb4_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_take(rd_take), .wr_take(wr_take),
  .wr_commit(wr_commit), .fwd_hit(fwd_hit), .rd_v_fall(rd_v_fall),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/qb4_sram_test.sv
module qb4_sram_test;
  localparam int DW = 16;
  localparam int BW = 8;
  localparam int NB = DW / BW;
  localparam int GW = 4;
  localparam int NG = 1 << GW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [GW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_bw_n = '1;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          echo_clk;

  qb4_sram #(.DATA_W(DW), .BYTE_W(BW), .GRP_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wr_data(wr_data), .wr_bw_n(wr_bw_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .echo_clk(echo_clk)
  );

  always #4 clk = ~clk;

  int            checks = 0;
  int            errors = 0;
  string         tag = "R10";
  logic [DW-1:0] ref_mem [NG*4];
  bit            exp_v [16];
  logic [DW-1:0] exp_d [16];
  logic [DW-1:0] qd [$];
  logic [NB-1:0] qm [$];
  int            cyc = 0;
  bit            rd_last = 0;
  bit            wr_last = 0;

  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", t, $time, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] put_bytes(input logic [DW-1:0] old_w,
                                              input logic [DW-1:0] d, input logic [NB-1:0] en_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int b = 0; b < NB; b++)
      if (en_n[b] == 1'b0) r[b*BW +: BW] = d[b*BW +: BW];
    return r;
  endfunction

  task automatic sample(input int h);
    int i;
    i = h % 16;
    check(rd_valid === exp_v[i], exp_v[i] ? "R7" : tag, 32'(rd_valid), 32'(exp_v[i]));
    if (exp_v[i]) check(rd_data === exp_d[i], tag, 32'(rd_data), 32'(exp_d[i]));
    else          check(rd_data === '0, "R9", 32'(rd_data), 32'd0);
    check(echo_clk === clk, "R11", 32'(echo_clk), 32'(clk));
    exp_v[i] = 1'b0;
  endtask

  task automatic drive_beat();
    if (qd.size() > 0) begin
      wr_data = qd.pop_front();
      wr_bw_n = qm.pop_front();
    end else begin
      wr_data = DW'($urandom);
      wr_bw_n = NB'($urandom);
    end
  endtask

  // One clock cycle. Entered shortly after a falling edge.
  task automatic tick(input bit rd, input int rg, input bit wr, input int wg, input bit rnd_mask);
    bit ra, wa;
    logic [DW-1:0] d;
    logic [NB-1:0] m;
    drive_beat();
    ra = rd && !rd_last;
    wa = wr && !wr_last;
    rd_sel_n = !rd;
    wr_sel_n = !wr;
    addr = rd ? GW'(rg) : GW'($urandom);
    if (wa) begin
      for (int b = 0; b < 4; b++) begin
        d = DW'($urandom);
        m = rnd_mask ? NB'($urandom) : '0;
        qd.push_back(d);
        qm.push_back(m);
        ref_mem[wg*4+b] = put_bytes(ref_mem[wg*4+b], d, m);
      end
    end
    if (ra) begin
      for (int b = 0; b < 4; b++) begin
        exp_v[(2*cyc+3+b) % 16] = 1'b1;
        exp_d[(2*cyc+3+b) % 16] = ref_mem[rg*4+b];
      end
    end
    rd_last = ra;
    wr_last = wa;
    @(posedge clk); #2 sample(2*cyc); #1;
    rd_sel_n = 1'b1;
    wr_sel_n = 1'b1;
    addr = wr ? GW'(wg) : GW'($urandom);
    drive_beat();
    @(negedge clk); #2 sample(2*cyc+1); #1;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
  endtask

  task automatic read_all();
    for (int g = 0; g < NG; g++) begin
      tick(1, g, 0, 0, 0);
      tick(0, 0, 0, 0, 0);
    end
    idle(4);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(rd_valid === 1'b0, "R10", 32'(rd_valid), 0);
    check(rd_data === '0, "R10", 32'(rd_data), 0);
    #1 rst_n = 1'b1;

    tag = "R2";   // fill every group with full masks, then read back in order
    for (int g = 0; g < NG; g++) begin
      tick(0, 0, 1, g, 0);
      tick(0, 0, 0, 0, 0);
    end
    read_all();

    tag = "R4";   // random byte enables for each beat
    for (int g = 0; g < 8; g++) begin
      tick(0, 0, 1, g, 1);
      tick(0, 0, 0, 0, 0);
    end
    read_all();

    tag = "R1";   // read and write accepted at the same edge, different groups
    for (int i = 0; i < 8; i++) begin
      tick(1, i, 1, NG-1-i, 1);
      tick(0, 0, 0, 0, 0);
    end
    idle(4);

    tag = "R8";   // same group: same edge, write first, read first
    for (int g = 0; g < 4; g++) begin
      tick(1, g, 1, g, 1);  tick(0, 0, 0, 0, 0);
      tick(0, 0, 1, g, 1);  tick(1, g, 0, 0, 0);  tick(0, 0, 0, 0, 0);
      tick(1, g, 0, 0, 0);  tick(0, 0, 1, g, 1);  tick(0, 0, 0, 0, 0);
    end
    idle(4);

    tag = "R6";   // selects held low for two cycles: the second is ignored
    for (int i = 0; i < 6; i++) begin
      tick(1, i, 1, i, 1);
      tick(1, (i+5) % NG, 1, (i+9) % NG, 1);
    end
    idle(4);
    read_all();

    tag = "R5";   // idle cycles with junk on data, enables and address
    idle(12);
    read_all();

    tag = "R10";  // reset in the middle of the run keeps the array
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    read_all();

    tag = "R3";   // random mix of reads, writes and idle cycles
    for (int i = 0; i < 3000; i++)
      tick(bit'($urandom % 2), int'($urandom % NG), bit'($urandom % 2), int'($urandom % NG), 1);
    idle(6);
    read_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule